// File: doc/BRIEF.md
# First-Level Data Cache Line Coherence State Machine

This block holds the four-state coherence status (invalid, shared, exclusive, modified) of a single line in a first-level data cache. Each clock it may see one of three events: a local read, a local write, or a snoop inquiry from another bus agent. The next state is chosen from sideband qualifiers. Two active-low qualifiers say whether the access may be cached: a cacheability request and a line-fill enable. An active-high page write-through attribute marks write-through pages. An active-high hint from the second-level cache allows the line to be held write-back. A snoop carries an invalidate flag.

Local writes follow a write-once policy. The first write to a shared line is written through to the second level, and if the qualifiers allow, the line becomes exclusive. Later writes then stay local. When a snoop finds the line present, the block reports a hit. When the line is modified, it also reports hit-modified and asks the surrounding controller to write the line back. Data storage, tag compare, replacement and the write-back bus cycle are handled elsewhere. Many instances of this block sit beside the tag array, one for each line.

States and transitions, with the state code used on `line_state`:

| State | Code |
|---|---|
| INV | 0 |
| SHR | 1 |
| EXC | 2 |
| MOD | 3 |

The named transitions are:

- fill-exclusive: INV to EXC
- fill-shared: INV to SHR
- no-fill: INV to INV
- read-hit: no change
- write-dirty: EXC or MOD to MOD
- write-once: SHR to EXC
- write-through: SHR to SHR, or INV to INV
- snoop-share: MOD, EXC or SHR to SHR
- snoop-kill: any state to INV

Top module: `l1_line_coherence`

## Requirements
- R1: After reset, `line_state` is 0 (INV) and `snp_hit`, `snp_hitm` and `wb_req` are all low.
- R2: A read while the line is in SHR, EXC or MOD leaves the state unchanged.
- R3: A read in INV moves the line to EXC (code 2) when `cacheable_n`, `fill_en_n` and `page_wt` are all 0 and `l2_wb` is 1.
- R4: A read in INV moves the line to SHR (code 1) when `cacheable_n` and `fill_en_n` are both 0 and either `l2_wb` is 0 or `page_wt` is 1.
- R5: A read in INV leaves the line in INV when `cacheable_n` or `fill_en_n` is 1.
- R6: A write while the line is in EXC or MOD moves it to MOD (code 3).
- R7: A write in SHR moves the line to EXC when `page_wt` is 0 and `l2_wb` is 1. Otherwise the line stays in SHR.
- R8: A write in INV leaves the line in INV. No allocation happens on a write.
- R9: A snoop moves SHR, EXC or MOD to INV when `snp_inv` is 1 and to SHR when it is 0. INV stays INV.
- R10: In the cycle after a snoop, `snp_hit` is 1 if the line was not INV. `snp_hitm` and `wb_req` are 1 only if the line was MOD. After any cycle without a snoop, all three are 0.
- R11: When `snp_req` is high, a read or write in the same cycle is ignored. Only the snoop transition occurs.
- R12: When `rd_req` and `wr_req` are both high and there is no snoop, the access is treated as a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_req | input | 1 | Local read to this line |
| wr_req | input | 1 | Local write to this line |
| snp_req | input | 1 | Snoop inquiry to this line |
| snp_inv | input | 1 | Snoop invalidate flag |
| cacheable_n | input | 1 | Cacheability request, active low |
| fill_en_n | input | 1 | Line-fill enable, active low |
| page_wt | input | 1 | Page write-through attribute |
| l2_wb | input | 1 | Second-level hint: 1 allows write-back |
| line_state | output | 2 | Current state code |
| snp_hit | output | 1 | Snoop found the line present |
| snp_hitm | output | 1 | Snoop found the line modified |
| wb_req | output | 1 | Request to write the modified line back |

## Verification
The bench targets four areas:

- **Qualifier decode on a fill.** A design that inverts the hint or the page write-through term would fill EXC where SHR is due. A read fill on a write-through page with the hint high is the decisive case.
- **Write-once edge in SHR.** Swapped qualifiers leave the line shared forever, or make it exclusive on a write-through page.
- **Snoop priority and simultaneous read-write.** A snoop arriving together with a write shows whether local traffic wins wrongly. A combined read and write on an invalid line shows a wrong fill when the read is favoured.
- **Snoop flags.** The flags are checked in the cycle after the snoop and in the idle cycle after that. A flag stuck high, or a hit-modified raised for a clean line, shows up there.

// File: rtl/l1c_pkg.sv
package l1c_pkg;
    localparam int ST_W = 2;

    typedef enum logic [ST_W-1:0] {
        LS_INV = 2'd0,
        LS_SHR = 2'd1,
        LS_EXC = 2'd2,
        LS_MOD = 2'd3
    } line_st_e;

    typedef struct packed {
        logic hit;
        logic hitm;
        logic wb;
    } snp_flags_t;
endpackage

// File: rtl/l1c_local_next.sv
module l1c_local_next
    import l1c_pkg::*;
(
    input  line_st_e cur,
    input  logic     rd,
    input  logic     wr,
    input  logic     cacheable_n,
    input  logic     fill_en_n,
    input  logic     page_wt,
    input  logic     l2_wb,
    output line_st_e nxt
);
    logic may_fill;
    logic own_ok;

    // The access may allocate only when both active-low qualifiers are low.
    assign may_fill = !cacheable_n && !fill_en_n;
    // Exclusive ownership is allowed only with a write-back hint on a write-back page.
    assign own_ok   = !page_wt && l2_wb;

    always_comb begin
        nxt = cur;
        if (wr) begin
            // A write wins over a read in the same cycle (R12).
            unique case (cur)
                LS_INV: nxt = LS_INV;                      // write-through, no allocate
                LS_SHR: nxt = own_ok ? LS_EXC : LS_SHR;    // write-once
                LS_EXC: nxt = LS_MOD;
                LS_MOD: nxt = LS_MOD;
            endcase
        end else if (rd) begin
            unique case (cur)
                LS_INV: begin
                    if (!may_fill)   nxt = LS_INV;
                    else if (own_ok) nxt = LS_EXC;
                    else             nxt = LS_SHR;
                end
                LS_SHR: nxt = LS_SHR;
                LS_EXC: nxt = LS_EXC;
                LS_MOD: nxt = LS_MOD;
            endcase
        end
    end
endmodule

// File: rtl/l1c_snoop_next.sv
module l1c_snoop_next
    import l1c_pkg::*;
(
    input  line_st_e   cur,
    input  logic       inv,
    output line_st_e   nxt,
    output snp_flags_t flg
);
    always_comb begin
        flg = '0;
        nxt = LS_INV;
        unique case (cur)
            LS_INV: begin
                nxt = LS_INV;
            end
            LS_SHR, LS_EXC: begin
                nxt     = inv ? LS_INV : LS_SHR;
                flg.hit = 1'b1;
            end
            LS_MOD: begin
                nxt      = inv ? LS_INV : LS_SHR;
                flg.hit  = 1'b1;
                flg.hitm = 1'b1;
                flg.wb   = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/l1_line_coherence.sv
module l1_line_coherence
    import l1c_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd_req,
    input  logic            wr_req,
    input  logic            snp_req,
    input  logic            snp_inv,
    input  logic            cacheable_n,
    input  logic            fill_en_n,
    input  logic            page_wt,
    input  logic            l2_wb,
    output logic [ST_W-1:0] line_state,
    output logic            snp_hit,
    output logic            snp_hitm,
    output logic            wb_req
);
    line_st_e   state_q;
    line_st_e   loc_nxt;
    line_st_e   snp_nxt;
    line_st_e   state_d;
    snp_flags_t snp_flg;
    snp_flags_t flg_q;

    l1c_local_next u_local (
        .cur         (state_q),
        .rd          (rd_req),
        .wr          (wr_req),
        .cacheable_n (cacheable_n),
        .fill_en_n   (fill_en_n),
        .page_wt     (page_wt),
        .l2_wb       (l2_wb),
        .nxt         (loc_nxt)
    );

    l1c_snoop_next u_snoop (
        .cur (state_q),
        .inv (snp_inv),
        .nxt (snp_nxt),
        .flg (snp_flg)
    );

    // A snoop overrides any local access in the same cycle.
    always_comb begin
        if (snp_req)               state_d = snp_nxt;
        else if (rd_req || wr_req) state_d = loc_nxt;
        else                       state_d = state_q;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LS_INV;
        else        state_q <= state_d;
    end

    // Output register: the flags hold for one cycle after a snoop.
    always_ff @(posedge clk) begin
        if (!rst_n)       flg_q <= '0;
        else if (snp_req) flg_q <= snp_flg;
        else              flg_q <= '0;
    end

    assign line_state = state_q;
    assign snp_hit    = flg_q.hit;
    assign snp_hitm   = flg_q.hitm;
    assign wb_req     = flg_q.wb;

    p_hitm_needs_hit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        snp_hitm |-> (snp_hit && wb_req));

    p_flags_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !snp_req |=> (!snp_hit && !snp_hitm && !wb_req));

    p_mod_snoop_wb_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_req && state_q == LS_MOD) |=> wb_req);

    p_snoop_kill_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_req && snp_inv) |=> (line_state == 2'd0));

    p_snoop_share_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_req && !snp_inv && state_q != LS_INV) |=> (line_state == 2'd1));

    p_write_dirty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!snp_req && wr_req && (state_q == LS_EXC || state_q == LS_MOD)) |=> (line_state == 2'd3));

    p_write_miss_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!snp_req && wr_req && state_q == LS_INV) |=> (line_state == 2'd0));

    p_no_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!snp_req && !wr_req && rd_req && state_q == LS_INV && (cacheable_n || fill_en_n))
            |=> (line_state == 2'd0));

    p_read_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!snp_req && !wr_req && rd_req && state_q != LS_INV) |=> $stable(line_state));
endmodule

// File: tb/sim_l1_line_coherence.sv
module sim_l1_line_coherence;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rd_req = 0, wr_req = 0, snp_req = 0, snp_inv = 0;
    logic cacheable_n = 1, fill_en_n = 1, page_wt = 0, l2_wb = 0;
    logic [1:0] line_state;
    logic snp_hit, snp_hitm, wb_req;

    int n_checks = 0;
    int n_fail = 0;
    int m_st = 0;
    int m_hit = 0, m_hitm = 0, m_wb = 0;

    always #4 clk = ~clk;

    l1_line_coherence u0 (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .wr_req(wr_req),
        .snp_req(snp_req), .snp_inv(snp_inv), .cacheable_n(cacheable_n),
        .fill_en_n(fill_en_n), .page_wt(page_wt), .l2_wb(l2_wb),
        .line_state(line_state), .snp_hit(snp_hit), .snp_hitm(snp_hitm), .wb_req(wb_req)
    );

    task automatic compare(input string tag);
        logic [4:0] act, exp;
        act = {line_state, snp_hit, snp_hitm, wb_req};
        exp = {m_st[1:0], m_hit[0], m_hitm[0], m_wb[0]};
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {state,hit,hitm,wb} actual %b expected %b", tag, act, exp);
        end
    endtask

    // Behavioural reference: one event per cycle.
    task automatic model(input bit rd, wr, snp, inv, cn, kn, pw, hb);
        m_hit = 0; m_hitm = 0; m_wb = 0;
        if (snp) begin
            m_hit  = (m_st != 0);
            m_hitm = (m_st == 3);
            m_wb   = m_hitm;
            if (m_st != 0) m_st = inv ? 0 : 1;
        end else if (wr) begin
            if (m_st >= 2) m_st = 3;
            else if (m_st == 1) m_st = (!pw && hb) ? 2 : 1;
        end else if (rd) begin
            if (m_st == 0) begin
                if (cn || kn) m_st = 0;
                else if (!pw && hb) m_st = 2;
                else m_st = 1;
            end
        end
    endtask

    task automatic step(input string tag, input bit rd, wr, snp, inv, cn, kn, pw, hb);
        rd_req = rd; wr_req = wr; snp_req = snp; snp_inv = inv;
        cacheable_n = cn; fill_en_n = kn; page_wt = pw; l2_wb = hb;
        model(rd, wr, snp, inv, cn, kn, pw, hb);
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    function automatic string classify(input bit rd, wr, snp, cn, kn, pw, hb);
        if (snp && (rd || wr)) return "R11";
        if (snp) return "R9 R10";
        if (rd && wr) return "R12";
        if (wr) return (m_st == 0) ? "R8" : (m_st == 1) ? "R7" : "R6";
        if (rd) begin
            if (m_st != 0) return "R2";
            if (cn || kn) return "R5";
            return (!pw && hb) ? "R3" : "R4";
        end
        return "R10 idle";
    endfunction

    initial begin
        #1600000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        compare("R1 reset");
        //   tag                 rd wr sn iv cn kn pw hb
        step("R5 nc",            1, 0, 0, 0, 1, 0, 0, 1);
        step("R5 no fill en",    1, 0, 0, 0, 0, 1, 0, 1);
        step("R3 fill exc",      1, 0, 0, 0, 0, 0, 0, 1);
        step("R2 hit exc",       1, 0, 0, 0, 0, 0, 1, 0);
        step("R6 exc to mod",    0, 1, 0, 0, 0, 0, 0, 0);
        step("R6 mod stays",     0, 1, 0, 0, 0, 0, 1, 1);
        step("R2 hit mod",       1, 0, 0, 0, 1, 1, 0, 0);
        step("R9 R10 snp mod",   0, 0, 1, 0, 0, 0, 0, 0);
        step("R10 flags clear",  0, 0, 0, 0, 0, 0, 0, 0);
        step("R7 wt page",       0, 1, 0, 0, 0, 0, 1, 1);
        step("R7 hint low",      0, 1, 0, 0, 0, 0, 0, 0);
        step("R2 hit shr",       1, 0, 0, 0, 0, 0, 0, 1);
        step("R7 write once",    0, 1, 0, 0, 0, 0, 0, 1);
        step("R9 R10 kill exc",  0, 0, 1, 1, 0, 0, 0, 0);
        step("R10 snp miss",     0, 0, 1, 0, 0, 0, 0, 0);
        step("R8 write miss",    0, 1, 0, 0, 0, 0, 0, 1);
        step("R4 fill hint low", 1, 0, 0, 0, 0, 0, 0, 0);
        step("R9 kill shr",      0, 0, 1, 1, 0, 0, 0, 0);
        step("R4 fill wt page",  1, 0, 0, 0, 0, 0, 1, 1);
        step("R11 snp vs write", 0, 1, 1, 0, 0, 0, 0, 1);
        step("R9 kill",          0, 0, 1, 1, 0, 0, 0, 0);
        step("R12 rd wr on inv", 1, 1, 0, 0, 0, 0, 0, 1);
        step("R3 refill",        1, 0, 0, 0, 0, 0, 0, 1);
        step("R12 rd wr on exc", 1, 1, 0, 0, 0, 0, 0, 1);
        step("R11 snp vs read",  1, 0, 1, 1, 0, 0, 0, 1);
        for (int i = 0; i < 600; i++) begin
            logic [7:0] r;
            r = 8'($urandom);
            step(classify(r[0], r[1], r[2] & r[7], r[4], r[5], r[6], r[3]),
                 r[0], r[1], r[2] & r[7], r[3] ^ r[6], r[4], r[5], r[6], r[3]);
        end
        // Reset in mid-stream returns to INV with flags low.
        rst_n = 1'b0;
        m_st = 0; m_hit = 0; m_hitm = 0; m_wb = 0;
        @(posedge clk);
        @(negedge clk);
        compare("R1 reset again");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule